// File: doc/BRIEF.md
# Dual Sum-of-Products Arithmetic Unit

This purely combinational datapath takes three unsigned operands A, B and C, each `N` bits wide. It returns two sums of products at once: P1 = A·B + A·C and P2 = A·C + B·C. Three multipliers form the products A·B, A·C and B·C. The A·C product is built once and feeds both final adders. Two adders made of full-adder cells then form the results.

Each multiplier is a chain of `N` slices with no multiply operator anywhere. Slice k uses one multiplier bit to select either the multiplicand or zero, through a row of two-input multiplexers. It places that gated value at weight 2^k and adds it to the running partial sum. Each partial sum is only as wide as its largest possible value, so the last slice gives the full 2N-bit product.

Both outputs are 2N+1 bits wide, so neither sum can overflow. The block has no clock and no state, and its outputs follow its inputs directly.

Top module: `sop_dual_unit`

## Requirements
- R1: `p1_o` equals A·B + A·C as an exact unsigned value of 2N+1 bits, for every input combination.
- R2: `p2_o` equals A·C + B·C as an exact unsigned value of 2N+1 bits, for every input combination.
- R3: With A = 0, `p1_o` is 0 and `p2_o` equals B·C.
- R4: With C = 0, `p1_o` equals A·B and `p2_o` is 0.
- R5: With B = 0, both outputs equal A·C, so the shared product reaches both adders unchanged.
- R6: With all three operands all-ones, both outputs equal 2·(2^N−1)^2. For N ≥ 2 this sets bit 2N, which is the top bit. No output ever exceeds 2·(2^N−1)^2.
- R7: With A = C, `p1_o` equals `p2_o` for any B.
- R8: With B = 2^k (only bit k set) and C = 0, `p1_o` equals A shifted left by k bit positions, for every k from 0 to N−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Unsigned operand A |
| b_i | input | N | Unsigned operand B |
| c_i | input | N | Unsigned operand C |
| p1_o | output | 2N+1 | A·B + A·C |
| p2_o | output | 2N+1 | A·C + B·C |

## Verification
The checker assumes that the three operands are fully known, 2-state values, and it skips evaluation while any operand bit is unknown. It also treats an output as valid as soon as the combinational network has settled, with no clock involved. The bench meets both assumptions. It drives every operand with defined values from time zero. It changes operands just after a clock edge and samples results only at the opposite edge, by which time the network has long settled.

// File: rtl/sop_pkg.sv
`timescale 1ns/1ps
package sop_pkg;

  typedef struct packed {
    logic sum;
    logic cout;
  } fa_t;

  function automatic fa_t full_add(input logic x, input logic y, input logic ci);
    fa_t r;
    r.sum  = x ^ y ^ ci;
    r.cout = (x & y) | (ci & (x ^ y));
    return r;
  endfunction

  // bit offset of partial-sum stage i in a packed bus; stage j is n+j bits wide
  function automatic int stage_off(input int n, input int i);
    return i * n + (i * (i - 1)) / 2;
  endfunction

endpackage

// File: rtl/sop_ripple_add.sv
`timescale 1ns/1ps
module sop_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W:0]   sum_o
);
  import sop_pkg::*;

  logic [W:0]   carry;
  logic [W-1:0] s;

  assign carry[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_bit
    fa_t r;
    assign r          = full_add(a_i[k], b_i[k], carry[k]);
    assign s[k]       = r.sum;
    assign carry[k+1] = r.cout;
  end

  assign sum_o = {carry[W], s};
endmodule

// File: rtl/sop_gate_row.sv
`timescale 1ns/1ps
module sop_gate_row #(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic         sel_i,
  output logic [W-1:0] gated_o
);
  for (genvar k = 0; k < W; k++) begin : g_mux
    assign gated_o[k] = sel_i ? data_i[k] : 1'b0;
  end
endmodule

// File: rtl/sop_mult_slice.sv
`timescale 1ns/1ps
module sop_mult_slice #(
  parameter int N   = 8,
  parameter int IDX = 0
) (
  input  logic [N-1:0]   mcand_i,
  input  logic           sel_i,
  input  logic [N+IDX-1:0] acc_i,
  output logic [N+IDX:0]   acc_o
);
  localparam int AW = N + IDX;

  logic [N-1:0]  gated;
  logic [AW-1:0] addend;

  sop_gate_row #(.W(N)) u_gate (
    .data_i (mcand_i),
    .sel_i  (sel_i),
    .gated_o(gated)
  );

  assign addend = AW'(gated) << IDX;

  sop_ripple_add #(.W(AW)) u_add (
    .a_i  (acc_i),
    .b_i  (addend),
    .sum_o(acc_o)
  );
endmodule

// File: rtl/sop_shift_add_mult.sv
`timescale 1ns/1ps
module sop_shift_add_mult #(
  parameter int N = 8
) (
  input  logic [N-1:0]   mcand_i,
  input  logic [N-1:0]   mplier_i,
  output logic [2*N-1:0] prod_o
);
  localparam int TOT = sop_pkg::stage_off(N, N + 1);

  // stage i occupies N+i bits; stage 0 is the zero seed, stage N the product
  logic [TOT-1:0] acc_bus;

  assign acc_bus[N-1:0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_slice
    localparam int OFF_IN  = sop_pkg::stage_off(N, i);
    localparam int OFF_OUT = sop_pkg::stage_off(N, i + 1);

    sop_mult_slice #(.N(N), .IDX(i)) u_slice (
      .mcand_i(mcand_i),
      .sel_i  (mplier_i[i]),
      .acc_i  (acc_bus[OFF_IN +: N+i]),
      .acc_o  (acc_bus[OFF_OUT +: N+i+1])
    );
  end

  assign prod_o = acc_bus[sop_pkg::stage_off(N, N) +: 2*N];
endmodule

// File: rtl/sop_dual_unit.sv
`timescale 1ns/1ps
module sop_dual_unit #(
  parameter int N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] c_i,
  output logic [2*N:0] p1_o,
  output logic [2*N:0] p2_o
);
  localparam int PW = 2 * N;

  logic [PW-1:0] prod_ab, prod_ac, prod_bc;

  sop_shift_add_mult #(.N(N)) u_mul_ab (.mcand_i(a_i), .mplier_i(b_i), .prod_o(prod_ab));
  sop_shift_add_mult #(.N(N)) u_mul_ac (.mcand_i(a_i), .mplier_i(c_i), .prod_o(prod_ac));
  sop_shift_add_mult #(.N(N)) u_mul_bc (.mcand_i(b_i), .mplier_i(c_i), .prod_o(prod_bc));

  // shared A*C fans out to both adders
  sop_ripple_add #(.W(PW)) u_add_p1 (.a_i(prod_ab), .b_i(prod_ac), .sum_o(p1_o));
  sop_ripple_add #(.W(PW)) u_add_p2 (.a_i(prod_ac), .b_i(prod_bc), .sum_o(p2_o));
endmodule

// File: rtl/sop_dual_unit_chk.sv
`timescale 1ns/1ps
module sop_dual_unit_chk #(
  parameter int N = 8
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic [N-1:0] c_i,
  input logic [2*N:0] p1_o,
  input logic [2*N:0] p2_o
);
  localparam int PW = 2 * N + 1;

  logic [PW-1:0] m_ab, m_ac, m_bc, lim;

  always_comb begin
    m_ab = PW'(a_i) * PW'(b_i);
    m_ac = PW'(a_i) * PW'(c_i);
    m_bc = PW'(b_i) * PW'(c_i);
    lim  = PW'(2) * (PW'({N{1'b1}}) * PW'({N{1'b1}}));
    if (!$isunknown({a_i, b_i, c_i, p1_o, p2_o})) begin
      a_r1_p1_sum: assert (p1_o == m_ab + m_ac)
        else $error("R1 p1 %0d exp %0d", p1_o, m_ab + m_ac);
      a_r2_p2_sum: assert (p2_o == m_ac + m_bc)
        else $error("R2 p2 %0d exp %0d", p2_o, m_ac + m_bc);
      a_r3_zero_a: assert (a_i != '0 || p1_o == '0)
        else $error("R3 p1 %0d with A zero", p1_o);
      a_r5_shared: assert (b_i != '0 || p1_o == p2_o)
        else $error("R5 p1 %0d p2 %0d with B zero", p1_o, p2_o);
      a_r6_no_overflow: assert (p1_o <= lim && p2_o <= lim)
        else $error("R6 p1 %0d p2 %0d above %0d", p1_o, p2_o, lim);
      a_r7_sym: assert (a_i != c_i || p1_o == p2_o)
        else $error("R7 p1 %0d p2 %0d with A==C", p1_o, p2_o);
    end
  end
endmodule

bind sop_dual_unit sop_dual_unit_chk #(.N(N)) u_chk (
  .a_i (a_i),
  .b_i (b_i),
  .c_i (c_i),
  .p1_o(p1_o),
  .p2_o(p2_o)
);

// File: tb/sop_dual_unit_tb.sv
`timescale 1ns/1ps
module sop_dual_unit_tb;
  localparam int N  = 8;
  localparam int PW = 2 * N + 1;

  typedef struct {
    logic [PW-1:0] e1;
    logic [PW-1:0] e2;
    string         req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] a = '0, b = '0, c = '0;
  logic [PW-1:0] p1, p2;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit fin = 1'b0;

  always #2.5 clk = ~clk;

  sop_dual_unit #(.N(N)) u_dut (
    .a_i (a),
    .b_i (b),
    .c_i (c),
    .p1_o(p1),
    .p2_o(p2)
  );

  function automatic logic [PW-1:0] mul(input logic [N-1:0] x, input logic [N-1:0] y);
    return PW'(x) * PW'(y);
  endfunction

  task automatic drive(input logic [N-1:0] xa, input logic [N-1:0] xb,
                       input logic [N-1:0] xc, input string req);
    exp_t it;
    @(posedge clk);
    #1;
    a = xa; b = xb; c = xc;
    it.e1  = mul(xa, xb) + mul(xa, xc);
    it.e2  = mul(xa, xc) + mul(xb, xc);
    it.req = req;
    q.push_back(it);
  endtask

  task automatic check(input string req, input string what,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: sample away from the driving edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        check(it.req, "p1", p1, it.e1);
        check(it.req, "p2", p2, it.e2);
      end
    end
  end

  task automatic finish_run();
    if (!fin) begin
      fin = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [N-1:0] ones;
    ones = '1;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // all zero at start: R3 and R4 both apply
    drive('0, '0, '0, "R3");
    drive('0, 8'd17, 8'd200, "R3");
    drive('0, ones, ones, "R3");
    drive(8'd99, 8'd45, '0, "R4");
    drive(ones, ones, '0, "R4");
    drive(8'd123, '0, 8'd77, "R5");
    drive(ones, '0, ones, "R5");
    drive(ones, ones, ones, "R6");
    drive(8'd1, 8'd1, 8'd1, "R1 R2");
    drive(8'd128, 8'd128, 8'd128, "R1 R2");
    for (int k = 0; k < N; k++) drive(8'hA5, N'(1) << k, '0, "R8");
    for (int k = 0; k < N; k++) drive(ones, N'(1) << k, '0, "R8");
    for (int i = 0; i < 8; i++) begin
      logic [N-1:0] r;
      r = N'($urandom);
      drive(r, N'($urandom), r, "R7");
    end
    for (int i = 0; i < 60; i++) drive(N'($urandom), N'($urandom), N'($urandom), "R1 R2");

    // direct check of the R6 closed form and top bit
    @(posedge clk);
    #1;
    a = ones; b = ones; c = ones;
    @(negedge clk);
    check("R6", "p1 value", p1, PW'(2) * (PW'(ones) * PW'(ones)));
    check("R6", "p1 msb", PW'(p1[PW-1]), PW'(1));
    check("R6", "p2 msb", PW'(p2[PW-1]), PW'(1));

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule